// File: doc/BRIEF.md
# Pen-Touch Interrupt and Converter Power Manager

This block sits beside the serial sequencer of a resistive touch-screen digitizer. It watches a touch-sense level from the panel and raises an active-low pen interrupt when the panel is pressed. It also decides whether the converter is powered and whether the low-side Y-minus driver is on. The Y-minus driver is the path that lets a touch pull the sense node. A two-bit power-down code sets these choices. The code is loaded with a strobe and comes up as `10` after reset.

The sequencer sends single-cycle pulses when it detects a start bit, when the fourth serial-clock falling edge after that start bit occurs, and when a conversion ends. Starting a conversion masks the interrupt and turns off the sensing driver. The interrupt is armed again only when the last outstanding conversion finishes, and only if the power-down code in force at that moment allows it. All logic runs on one system clock, and the serial-clock events arrive as enable pulses. The interrupt pin is modelled as a drive-low enable and a resolved level that idles high.

Top module: `pen_power_ctl`

## Requirements
- R1: After reset the power-down code is `10`: `adc_pwr_en` is 1, `yneg_drv_on` is 1 and `pen_irq_n` is 1 while no touch is present.
- R2: `touch_in` passes through a two-flop synchronizer. When the interrupt is armed and `touch_in` rises, `pen_irq_n` falls after the second rising clock edge, and not after the first.
- R3: When code bit 1 is set (codes `10`, `11`), `adc_pwr_en` is 1 in every cycle after the load takes effect.
- R4: When code bit 0 is set (codes `01`, `11`), a touch while idle does not drive the interrupt low, and `yneg_drv_on` is 0.
- R5: In the cycle after `start_det`, `yneg_drv_on` is 0 and touches have no effect on `pen_irq_n`. The only exception is the hold described in R6.
- R6: If the interrupt is being driven low when `start_det` arrives, it stays low until the `dclk_fall4` pulse. In the cycle after that pulse, `pen_irq_n` is 1.
- R7: When the last outstanding conversion ends (`eoc`) and code bit 0 is clear, the next cycle has `yneg_drv_on` at 1 and the interrupt follows the synchronized touch again. The code used is the one loaded last, even if it was loaded during the conversion.
- R8: When code bit 1 is clear (codes `00`, `01`), `adc_pwr_en` is 1 from the cycle after `start_det` until the cycle after the final `eoc`, and 0 otherwise.
- R9: A `start_det` that arrives before the `eoc` of the running conversion, or in the same cycle as it, counts as a further conversion. The block stays masked and powered through that `eoc` and re-arms only at the `eoc` of the last conversion.
- R10: `pen_irq_drv` and `pen_irq_n` are complementary in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| touch_in | input | 1 | Raw touch-sense level from the panel (1 = pressed) |
| pd_code | input | 2 | Power-down code: bit 1 keeps the converter powered, bit 0 disables the interrupt |
| pd_load | input | 1 | Strobe that loads `pd_code` |
| start_det | input | 1 | Pulse: start bit detected |
| dclk_fall4 | input | 1 | Pulse: fourth serial-clock falling edge after start |
| eoc | input | 1 | Pulse: conversion complete |
| pen_irq_drv | output | 1 | Drive-low enable of the open-drain interrupt |
| pen_irq_n | output | 1 | Resolved interrupt level, idles high |
| adc_pwr_en | output | 1 | Converter power enable |
| yneg_drv_on | output | 1 | Y-minus low-side driver enable |

## Verification
The bench runs the same sequence under each of the four power-down codes: touch while idle, start, fourth-edge release, end of conversion. It also runs overlap cases: a second start before the end of conversion, and a start in the same cycle as the end of conversion. If the hold flag were dropped, a touch interrupt would end early at start. If a second start were ignored, the block would re-arm after the first end of conversion and raise a spurious interrupt while converting. A code loaded during a conversion is checked at the following end of conversion. A design that latched the code at start would wrongly re-arm after that end of conversion. The synchronizer latency is checked edge by edge, so a missing or extra stage shows up as a one-cycle shift.

// File: rtl/pen_power_ctl.sv
module pen_power_ctl #(
  parameter int SYNC_STAGES = 2,
  parameter logic [1:0] PD_RESET = 2'b10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       touch_in,
  input  logic [1:0] pd_code,
  input  logic       pd_load,
  input  logic       start_det,
  input  logic       dclk_fall4,
  input  logic       eoc,
  output logic       pen_irq_drv,
  output logic       pen_irq_n,
  output logic       adc_pwr_en,
  output logic       yneg_drv_on
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [1:0] pd_q;
  logic [1:0] busy_cnt;
  logic [1:0] busy_nxt;
  logic       masked_q;
  logic       hold_q;
  logic       armed;
  logic       touch_s;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], touch_in};

  assign touch_s = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       pd_q <= PD_RESET;
    else if (pd_load) pd_q <= pd_code;

  always_comb begin
    busy_nxt = busy_cnt;
    if (eoc && busy_cnt != 2'd0) busy_nxt = busy_nxt - 2'd1;
    if (start_det && busy_nxt != 2'd2) busy_nxt = busy_nxt + 2'd1;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy_cnt <= 2'd0;
      masked_q <= 1'b0;
      hold_q   <= 1'b0;
    end else begin
      busy_cnt <= busy_nxt;
      if (start_det)
        masked_q <= 1'b1;
      else if (eoc && busy_nxt == 2'd0)
        masked_q <= 1'b0;
      if (start_det)
        hold_q <= pen_irq_drv;
      else if (dclk_fall4)
        hold_q <= 1'b0;
    end

  assign armed       = !masked_q && !pd_q[0];
  assign pen_irq_drv = hold_q || (armed && touch_s);
  assign pen_irq_n   = pen_irq_drv ? 1'b0 : 1'b1;
  assign adc_pwr_en  = pd_q[1] || (busy_cnt != 2'd0);
  assign yneg_drv_on = armed;

  // R5
  start_masks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !yneg_drv_on);

  // R6
  edge4_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dclk_fall4 && !start_det && (masked_q || pd_q[0]) && !eoc && !pd_load) |=> pen_irq_n);

  // R3
  power_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_load && pd_code[1]) |=> adc_pwr_en);

  // R7
  rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eoc && !start_det && !pd_load && busy_cnt == 2'd1 && pd_q == 2'b00) |=> (yneg_drv_on && !adc_pwr_en));

  // R9
  overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det && busy_cnt != 2'd0) |=> (adc_pwr_en && !yneg_drv_on));

  // R10
  always_comb
    if (rst_n) complement_chk: assert (pen_irq_n == !pen_irq_drv);

endmodule

// File: tb/test_pen_power_ctl.sv
module test_pen_power_ctl;
  logic clk = 0, rst_n = 0, touch_in = 0, pd_load = 0, start_det = 0, dclk_fall4 = 0, eoc = 0;
  logic [1:0] pd_code = 2'b00;
  logic pen_irq_drv, pen_irq_n, adc_pwr_en, yneg_drv_on;
  int checks = 0, errors = 0;

  pen_power_ctl i_pen_power_ctl (.*);

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic load(input logic [1:0] c);
    pd_code = c; pd_load = 1; tick(); pd_load = 0;
  endtask

  task automatic p_start(); start_det = 1; tick(); start_det = 0; endtask
  task automatic p_edge4(); dclk_fall4 = 1; tick(); dclk_fall4 = 0; endtask
  task automatic p_eoc();   eoc = 1; tick(); eoc = 0; endtask

  initial begin
    tick(2); rst_n = 1; tick();
    // R1
    chk("R1 pwr", adc_pwr_en, 1); chk("R1 yneg", yneg_drv_on, 1); chk("R1 irq", pen_irq_n, 1);
    // R2 latency
    touch_in = 1; tick(); chk("R2 first edge", pen_irq_n, 1);
    tick(); chk("R2 second edge", pen_irq_n, 0); chk("R10", pen_irq_drv, 1);
    touch_in = 0; tick(3);

    for (int c = 0; c < 4; c++) begin
      logic [1:0] cd;
      cd = c[1:0];
      load(cd); touch_in = 1; tick(3);
      chk("R4/R2 idle irq", pen_irq_n, cd[0]);
      chk("R4 idle yneg", yneg_drv_on, !cd[0]);
      chk("R3/R8 idle pwr", adc_pwr_en, cd[1]);
      p_start();
      chk("R5 yneg", yneg_drv_on, 0);
      chk("R8 pwr conv", adc_pwr_en, 1);
      chk("R6 held", pen_irq_n, cd[0]);
      touch_in = 0; tick(3);
      chk("R6 hold ignores touch", pen_irq_n, cd[0]);
      touch_in = 1; tick(2);
      p_edge4();
      chk("R6 release", pen_irq_n, 1);
      touch_in = 0; tick(2); touch_in = 1; tick(3);
      chk("R5 masked", pen_irq_n, 1);
      p_eoc();
      chk("R7 yneg", yneg_drv_on, !cd[0]);
      chk("R8/R3 pwr after", adc_pwr_en, cd[1]);
      chk("R7 irq", pen_irq_n, cd[0]);
      chk("R10", pen_irq_drv, !pen_irq_n);
      touch_in = 0; tick(3);
    end

    // R9 overlapped start before eoc
    load(2'b00); touch_in = 1; tick(3);
    p_start(); p_edge4(); p_start();
    p_eoc();
    chk("R9 masked irq", pen_irq_n, 1); chk("R9 yneg", yneg_drv_on, 0); chk("R9 pwr", adc_pwr_en, 1);
    p_edge4(); p_eoc();
    chk("R9 rearm yneg", yneg_drv_on, 1); chk("R9 rearm pwr", adc_pwr_en, 0); chk("R9 rearm irq", pen_irq_n, 0);

    // R9 start coincident with eoc
    p_start(); p_edge4();
    start_det = 1; eoc = 1; tick(); start_det = 0; eoc = 0;
    chk("R9 same-cycle pwr", adc_pwr_en, 1); chk("R9 same-cycle yneg", yneg_drv_on, 0);
    p_edge4(); p_eoc();
    chk("R9 same-cycle rearm", yneg_drv_on, 1);

    // R7 code loaded mid-conversion decides re-arm
    p_start(); load(2'b01); p_edge4(); p_eoc();
    chk("R7 new code yneg", yneg_drv_on, 0); chk("R7 new code irq", pen_irq_n, 1);
    chk("R8 new code pwr", adc_pwr_en, 0);
    load(2'b00); tick();
    chk("R7 armed again", pen_irq_n, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule